// File: doc/BRIEF.md
# Cross-VP Do-Across Ring Channel

This block carries loop-carried values between virtual processors (VPs) that are striped over a set of lanes. VP v runs on lane v mod NUM_LANES. VP v may pass exactly one value forward, and only to VP v+1, which is the next loop iteration. Each lane sends through a valid/ready port. The value arrives on the receive port of the next lane. The last lane feeds lane 0, where the next VP group picks it up. A receiver waits as long as its valid is low, so only the send/receive chain is serialised and all other lane work runs freely.

Every lane-to-lane link is a one-entry buffer. A write and a read on a full buffer in the same cycle pass the new value through with no bubble. The link into lane 0 can also be loaded from an external seed port, which gives VP 0 its starting value. The send made by the final VP (NUM_VPS-1) does not wrap. It goes to a drain buffer that exposes the result of the chain. The tail lane tells the final VP apart by counting its own accepted sends modulo the number of VPs per lane.

Top module: `vt_xvp_ring`

## Requirements
- R1: After reset every rcv_valid and drain_valid is 0, and every snd_ready and seed_ready is 1.
- R2: A send accepted on lane k (k < NUM_LANES-1) appears on lane k+1's receive port in the next cycle with the same data.
- R3: Sends accepted on the last lane are numbered 0,1,2,… from reset. Send n goes to lane 0's receive port in the next cycle unless n mod (NUM_VPS/NUM_LANES) equals NUM_VPS/NUM_LANES-1. In that case it goes to the drain port in the next cycle.
- R4: rcv_valid is 0 while its link is empty. While rcv_valid is 1 and rcv_ready is 0, valid and data hold unchanged.
- R5: snd_ready is 0 while the destination buffer is full and that buffer is not being read in the same cycle.
- R6: When a full buffer is read and written in the same cycle, the new value is stored and the old one is delivered. No value is lost or duplicated.
- R7: Values on each link are delivered in the order they were accepted.
- R8: A seed handshake loads the link into lane 0, and the value appears there in the next cycle. seed_ready is 0 whenever that link cannot accept or the last lane is presenting a wrapping send.
- R9: The drain port holds one value with valid/ready and behaves like the other links.
- R10: A chain that is seeded with S, where VP v receives x and sends x+v+1 for v = 0..NUM_VPS-1, ends with S + NUM_VPS·(NUM_VPS+1)/2 on the drain port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_valid | input | NUM_LANES | Per-lane send valid |
| snd_data | input | NUM_LANES*W | Per-lane send data, lane k in bits [k*W +: W] |
| snd_ready | output | NUM_LANES | Per-lane send accepted |
| rcv_valid | output | NUM_LANES | Per-lane receive data present |
| rcv_data | output | NUM_LANES*W | Per-lane receive data, lane k in bits [k*W +: W] |
| rcv_ready | input | NUM_LANES | Per-lane receive consume |
| seed_valid | input | 1 | Initial value offered for VP 0 |
| seed_data | input | W | Initial value |
| seed_ready | output | 1 | Seed accepted |
| drain_valid | output | 1 | Final chain value present |
| drain_data | output | W | Final chain value |
| drain_ready | input | 1 | Final value consumed |

## Verification
The first pattern is a strict do-across chain. One VP at a time receives and sends in the same cycle, starting from a seed. This pattern separates correct tail routing from a wrap that leaks into, or misses, the drain port, because only the final sum reveals a misplaced hop. The second pattern drives random valids, readies and seeds on every port at once. A cycle-accurate queue model compares every output on every clock. This pattern exposes missing back-pressure, dropped or doubled values on simultaneous read and write, and the wrong seed-versus-wrap priority. A counter in the bench confirms that pass-through on a full buffer actually occurred.

// File: rtl/vt_xvp_pkg.sv
package vt_xvp_pkg;
   // width of a counter that indexes n slots, never less than one bit
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/vt_xvp_link.sv
module vt_xvp_link #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   output logic         in_ready,
   output logic         out_valid,
   output logic [W-1:0] out_data,
   input  logic         out_ready
);
   logic         full_q;
   logic [W-1:0] data_q;

   // a full slot still accepts when it is emptied in the same cycle
   assign in_ready  = !full_q || out_ready;
   assign out_valid = full_q;
   assign out_data  = data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else if (in_valid && in_ready) begin
         full_q <= 1'b1;
         data_q <= in_data;
      end else if (out_ready) begin
         full_q <= 1'b0;
      end
   end

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));
   // R2
   land_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid && out_data == $past(in_data));
endmodule

// File: rtl/vt_xvp_tail_router.sv
module vt_xvp_tail_router #(
   parameter int unsigned W   = 32,
   parameter int unsigned VPL = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         s_valid,
   input  logic [W-1:0] s_data,
   output logic         s_ready,
   output logic         w_valid,
   output logic [W-1:0] w_data,
   input  logic         w_ready,
   output logic         d_valid,
   output logic [W-1:0] d_data,
   input  logic         d_ready
);
   import vt_xvp_pkg::*;
   localparam int unsigned CW = idx_bits(VPL);

   logic last;

   generate
      if (VPL == 1) begin : g_single
         // one VP per lane on the tail: every tail send is the final one
         assign last = 1'b1;
      end else begin : g_count
         logic [CW-1:0] slot_q;
         assign last = (slot_q == CW'(VPL - 1));
         always_ff @(posedge clk) begin
            if (!rst_n)
               slot_q <= '0;
            else if (s_valid && s_ready)
               slot_q <= last ? '0 : slot_q + 1'b1;
         end
      end
   endgenerate

   assign w_valid = s_valid && !last;
   assign d_valid = s_valid && last;
   assign w_data  = s_data;
   assign d_data  = s_data;
   assign s_ready = last ? d_ready : w_ready;
endmodule

// File: rtl/vt_xvp_seed_merge.sv
module vt_xvp_seed_merge #(
   parameter int unsigned W = 32
) (
   input  logic         w_valid,
   input  logic [W-1:0] w_data,
   output logic         w_ready,
   input  logic         seed_valid,
   input  logic [W-1:0] seed_data,
   output logic         seed_ready,
   output logic         m_valid,
   output logic [W-1:0] m_data,
   input  logic         m_ready
);
   // the wrapping send from the tail lane wins over the seed
   assign m_valid    = w_valid || seed_valid;
   assign m_data     = w_valid ? w_data : seed_data;
   assign w_ready    = m_ready;
   assign seed_ready = m_ready && !w_valid;
endmodule

// File: rtl/vt_xvp_ring.sv
module vt_xvp_ring #(
   parameter int unsigned NUM_LANES = 4,
   parameter int unsigned NUM_VPS   = 16,
   parameter int unsigned W         = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_LANES-1:0]   snd_valid,
   input  logic [NUM_LANES*W-1:0] snd_data,
   output logic [NUM_LANES-1:0]   snd_ready,
   output logic [NUM_LANES-1:0]   rcv_valid,
   output logic [NUM_LANES*W-1:0] rcv_data,
   input  logic [NUM_LANES-1:0]   rcv_ready,
   input  logic                   seed_valid,
   input  logic [W-1:0]           seed_data,
   output logic                   seed_ready,
   output logic                   drain_valid,
   output logic [W-1:0]           drain_data,
   input  logic                   drain_ready
);
   localparam int unsigned VPL  = NUM_VPS / NUM_LANES;
   localparam int unsigned TAIL = NUM_LANES - 1;

   generate
      if (NUM_LANES < 2) begin : g_bad_lanes
         $error("vt_xvp_ring: NUM_LANES must be at least 2");
      end
      if (NUM_VPS % NUM_LANES != 0 || NUM_VPS == 0) begin : g_bad_vps
         $error("vt_xvp_ring: NUM_VPS must be a nonzero multiple of NUM_LANES");
      end
      if (W < 1) begin : g_bad_w
         $error("vt_xvp_ring: W must be at least 1");
      end
   endgenerate

   logic [NUM_LANES-1:0] lk_valid;
   logic [NUM_LANES-1:0] lk_ready;
   logic [W-1:0]         lk_data [NUM_LANES];

   logic         wr_valid, wr_ready;
   logic [W-1:0] wr_data;
   logic         dr_valid, dr_ready;
   logic [W-1:0] dr_data;

   vt_xvp_tail_router #(.W(W), .VPL(VPL)) u_tail (
      .clk     (clk),
      .rst_n   (rst_n),
      .s_valid (snd_valid[TAIL]),
      .s_data  (snd_data[TAIL*W +: W]),
      .s_ready (snd_ready[TAIL]),
      .w_valid (wr_valid),
      .w_data  (wr_data),
      .w_ready (wr_ready),
      .d_valid (dr_valid),
      .d_data  (dr_data),
      .d_ready (dr_ready)
   );

   vt_xvp_seed_merge #(.W(W)) u_merge (
      .w_valid    (wr_valid),
      .w_data     (wr_data),
      .w_ready    (wr_ready),
      .seed_valid (seed_valid),
      .seed_data  (seed_data),
      .seed_ready (seed_ready),
      .m_valid    (lk_valid[0]),
      .m_data     (lk_data[0]),
      .m_ready    (lk_ready[0])
   );

   for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
      if (k > 0) begin : g_fwd
         // lane k-1 feeds lane k directly
         assign lk_valid[k]   = snd_valid[k-1];
         assign lk_data[k]    = snd_data[(k-1)*W +: W];
         assign snd_ready[k-1] = lk_ready[k];
      end
      vt_xvp_link #(.W(W)) u_link (
         .clk       (clk),
         .rst_n     (rst_n),
         .in_valid  (lk_valid[k]),
         .in_data   (lk_data[k]),
         .in_ready  (lk_ready[k]),
         .out_valid (rcv_valid[k]),
         .out_data  (rcv_data[k*W +: W]),
         .out_ready (rcv_ready[k])
      );
   end

   vt_xvp_link #(.W(W)) u_drain (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (dr_valid),
      .in_data   (dr_data),
      .in_ready  (dr_ready),
      .out_valid (drain_valid),
      .out_data  (drain_data),
      .out_ready (drain_ready)
   );

   // R8
   seed_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seed_valid && seed_ready |=> rcv_valid[0] && rcv_data[W-1:0] == $past(seed_data));
   // R3
   tail_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snd_valid[TAIL] && snd_ready[TAIL] |=>
         (rcv_valid[0] && rcv_data[W-1:0] == $past(snd_data[TAIL*W +: W])) ||
         (drain_valid && drain_data == $past(snd_data[TAIL*W +: W])));
endmodule

// File: tb/vt_xvp_ring_bench.sv
module vt_xvp_ring_bench;
   localparam int NL  = 4;
   localparam int NV  = 16;
   localparam int W   = 32;
   localparam int VPL = NV / NL;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NL-1:0]   snd_valid = '0;
   logic [NL*W-1:0] snd_data = '0;
   logic [NL-1:0]   snd_ready;
   logic [NL-1:0]   rcv_valid;
   logic [NL*W-1:0] rcv_data;
   logic [NL-1:0]   rcv_ready = '0;
   logic            seed_valid = 1'b0;
   logic [W-1:0]    seed_data = '0;
   logic            seed_ready;
   logic            drain_valid;
   logic [W-1:0]    drain_data;
   logic            drain_ready = 1'b0;

   always #5 clk = ~clk;

   vt_xvp_ring #(.NUM_LANES(NL), .NUM_VPS(NV), .W(W)) u_vt_xvp_ring (
      .clk(clk), .rst_n(rst_n),
      .snd_valid(snd_valid), .snd_data(snd_data), .snd_ready(snd_ready),
      .rcv_valid(rcv_valid), .rcv_data(rcv_data), .rcv_ready(rcv_ready),
      .seed_valid(seed_valid), .seed_data(seed_data), .seed_ready(seed_ready),
      .drain_valid(drain_valid), .drain_data(drain_data), .drain_ready(drain_ready)
   );

   int checks = 0;
   int failures = 0;

   // reference model: slots 0..NL-1 feed lanes, slot NL is the drain
   bit          m_full [NL+1];
   logic [31:0] m_dat  [NL+1];
   int          m_slot;
   int          pass_thru;
   int          drains;
   logic [31:0] last_drain;
   bit          e_sr [NL];
   bit          e_seed;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic bit rdy(input int j);
      return (j < NL) ? rcv_ready[j] : drain_ready;
   endfunction

   function automatic bit space(input int j);
      return !m_full[j] || rdy(j);
   endfunction

   task automatic eval();
      bit lastv, wrap;
      lastv = (m_slot == VPL - 1);
      for (int k = 0; k < NL - 1; k++) e_sr[k] = space(k + 1);
      e_sr[NL-1] = lastv ? space(NL) : space(0);
      wrap   = snd_valid[NL-1] && !lastv;
      e_seed = space(0) && !wrap;
   endtask

   task automatic model_reset();
      for (int j = 0; j <= NL; j++) begin m_full[j] = 0; m_dat[j] = '0; end
      m_slot = 0;
   endtask

   // compare all outputs, then advance the model at the clock edge
   task automatic cyc();
      bit          push [NL+1];
      logic [31:0] pdat [NL+1];
      #1;
      eval();
      for (int k = 0; k < NL; k++) begin
         chk(rcv_valid[k] == m_full[k], "R4", $sformatf("rcv_valid[%0d]", k), 32'(rcv_valid[k]), 32'(m_full[k]));
         if (m_full[k])
            chk(rcv_data[k*W +: W] == m_dat[k], (k == 0) ? "R3" : "R7", $sformatf("rcv_data[%0d]", k), rcv_data[k*W +: W], m_dat[k]);
         chk(snd_ready[k] == e_sr[k], (k == NL - 1) ? "R3" : "R5", $sformatf("snd_ready[%0d]", k), 32'(snd_ready[k]), 32'(e_sr[k]));
      end
      chk(seed_ready == e_seed, "R8", "seed_ready", 32'(seed_ready), 32'(e_seed));
      chk(drain_valid == m_full[NL], "R9", "drain_valid", 32'(drain_valid), 32'(m_full[NL]));
      if (m_full[NL]) chk(drain_data == m_dat[NL], "R9", "drain_data", drain_data, m_dat[NL]);
      for (int j = 0; j <= NL; j++) begin push[j] = 0; pdat[j] = '0; end
      for (int k = 0; k < NL - 1; k++)
         if (snd_valid[k] && e_sr[k]) begin push[k+1] = 1; pdat[k+1] = snd_data[k*W +: W]; end
      if (snd_valid[NL-1] && e_sr[NL-1]) begin
         if (m_slot == VPL - 1) begin push[NL] = 1; pdat[NL] = snd_data[(NL-1)*W +: W]; end
         else begin push[0] = 1; pdat[0] = snd_data[(NL-1)*W +: W]; end
      end
      if (seed_valid && e_seed) begin push[0] = 1; pdat[0] = seed_data; end
      @(posedge clk);
      if (snd_valid[NL-1] && e_sr[NL-1]) m_slot = (m_slot == VPL - 1) ? 0 : m_slot + 1;
      for (int j = 0; j <= NL; j++) begin
         if (m_full[j] && rdy(j)) begin
            if (j == NL) begin drains++; last_drain = m_dat[j]; end
            if (push[j]) pass_thru++;
            m_full[j] = 0;
         end
         if (push[j]) begin m_full[j] = 1; m_dat[j] = pdat[j]; end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int vp, guard;
      bit seeded;
      model_reset();
      pass_thru = 0; drains = 0; last_drain = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk(rcv_valid == '0, "R1", "rcv_valid", 32'(rcv_valid), 0);
      chk(!drain_valid, "R1", "drain_valid", 32'(drain_valid), 0);
      chk(snd_ready == '1, "R1", "snd_ready", 32'(snd_ready), 32'hf);
      chk(seed_ready, "R1", "seed_ready", 32'(seed_ready), 1);

      // R10 directed do-across chain
      vp = 0; seeded = 0; guard = 0;
      while ((vp < NV || m_full[NL]) && guard < 400) begin
         int lane;
         @(negedge clk);
         guard++;
         snd_valid = '0; rcv_ready = '0; drain_ready = 1'b1;
         seed_valid = !seeded; seed_data = 32'd100;
         if (seed_valid) seeded = 1;
         if (vp < NV) begin
            lane = vp % NL;
            if (m_full[lane]) begin
               snd_valid[lane] = 1'b1;
               snd_data[lane*W +: W] = m_dat[lane] + 32'(vp + 1);
               eval();
               if (e_sr[lane]) begin rcv_ready[lane] = 1'b1; vp++; end
               else snd_valid[lane] = 1'b0;
            end
         end
         cyc();
      end
      chk(drains == 1, "R10", "drain count", 32'(drains), 1);
      chk(last_drain == 32'd236, "R10", "chain result", last_drain, 32'd236);

      // random traffic on all ports, R2..R9 via model compare
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         for (int k = 0; k < NL; k++) begin
            snd_valid[k] = ($urandom % 3) != 0;
            snd_data[k*W +: W] = $urandom;
            rcv_ready[k] = ($urandom % 2) != 0;
         end
         seed_valid  = ($urandom % 4) == 0;
         seed_data   = $urandom;
         drain_ready = ($urandom % 2) != 0;
         cyc();
      end
      // R6 pass-through on a full buffer must have been exercised
      chk(pass_thru > 0, "R6", "pass-through events", 32'(pass_thru), 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule